// File: doc/BRIEF.md
# Serial Transmitter with Break Sequencing

This block is the transmit half of one asynchronous serial channel. A host hands it characters over a valid/ready stream. It keeps one character in a holding register and shifts another out on the serial line. Each character goes out as a fixed frame: one start bit, eight data bits with the least significant bit first, and one stop bit. A free-running strobe at sixteen times the bit rate sets the bit timing. Each bit lasts sixteen strobe pulses.

Single-cycle command pulses control the block. They enable the transmitter, disable it, reset it, start a break and end a break. Disabling is graceful: whatever is already loaded still goes out. A break is a long low level on the line. It is ordered behind any characters already held or in flight. When a break ends, the line is held high for one full bit before the next start bit.

Back-pressure follows the usual stream rules. A character moves on the clock edge where `in_valid` and `in_ready` are both high. The host must hold `in_valid` and `in_data` steady until that edge. `in_ready` also serves as the "ready for a character" status bit.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset the transmitter is disabled: `txd` is 1, `in_ready` is 0 and `tx_empty` is 0.
- R2: A `cmd_en` pulse enables the transmitter. From the next cycle, `in_ready` is 1 whenever the holding register is free.
- R3: `in_ready` is 1 only under all of the following conditions, and a character is taken only on a cycle with `in_valid` and `in_ready` both high:
  - the transmitter is enabled;
  - the holding register is empty;
  - no break is on the line;
  - a requested break is not starting at that cycle's bit boundary.
- R4: The line idles at 1. A frame is a start bit (0), then data bits 0 through 7, then a stop bit (1). Each bit lasts 16 `tick` pulses.
- R5: A character waiting in the holding register starts its start bit right after the previous stop bit ends, with no idle time between them.
- R6: `tx_empty` is 1 exactly when the transmitter is enabled, the holding register is empty and no frame, break or post-break mark is being sent.
- R7: A `cmd_dis` pulse clears `in_ready` and `tx_empty` from the next cycle. Characters already in the shifter and in the holding register are still sent in full.
- R8: When `cmd_en` and `cmd_dis` arrive in the same cycle, the transmitter ends up disabled.
- R9: `cmd_brk_on` is ignored unless the transmitter was already enabled before that cycle. An ignored request leaves the line high.
- R10: If the transmitter is idle and enabled, `cmd_brk_on` drives `txd` to 0 within two bit times. The line stays at 0 until `cmd_brk_off`.
- R11: A break requested while characters are held or being sent begins only after all of them have been sent, including any accepted after the request.
- R12: `cmd_brk_off` returns `txd` to 1 within two bit times. The line then stays at 1 for a full bit time before the next start bit. If `cmd_brk_on` and `cmd_brk_off` arrive together, the break ends.
- R13: A `cmd_rst` pulse has the same effect as a hardware reset: the transmitter is disabled, the held character and any break request are dropped, and `txd` returns to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Strobe at 16x the bit rate |
| cmd_en | input | 1 | Enable pulse |
| cmd_dis | input | 1 | Disable pulse (wins over enable) |
| cmd_rst | input | 1 | Transmitter reset pulse |
| cmd_brk_on | input | 1 | Start-break pulse |
| cmd_brk_off | input | 1 | Stop-break pulse |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Character can be taken (ready status) |
| tx_empty | output | 1 | Enabled with nothing held or on the line |
| txd | output | 1 | Serial output line |

## Verification
Most faults inside this block show up on `txd` or on the two status bits within one clock. Examples are a wrong bit index, a shift at the wrong time, or a missed clear of the holding flag. A wrong level or a mistimed edge appears at the next strobe, and a wrong `in_ready` appears in the very cycle it is evaluated. Faults in break ordering or enable state can stay hidden until the next bit boundary. That can be a full frame later (160 strobes), so the scenarios deliberately stack a held character behind a busy shifter before issuing disable or break. A reference model is compared every clock, so any difference is reported in the cycle it first appears.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHAR,
    ST_BRK,
    ST_GAP
  } utx_st_e;
endpackage

// File: rtl/utx_ctrl.sv
module utx_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              cmd_brk_on,
  input  logic              cmd_brk_off,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  input  logic              boundary,
  input  logic              in_brk,
  output logic              in_ready,
  output logic              en,
  output logic              hold_v,
  output logic [DATA_W-1:0] hold_d,
  output logic              brk_req
);
  // A character may not slip in on the cycle where a requested break launches.
  always_comb in_ready = en & ~hold_v & ~in_brk & ~(brk_req & boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      brk_req <= 1'b0;
      hold_v  <= 1'b0;
      hold_d  <= '0;
    end else if (clr) begin
      en      <= 1'b0;
      brk_req <= 1'b0;
      hold_v  <= 1'b0;
      hold_d  <= '0;
    end else begin
      if (cmd_dis)     en <= 1'b0;
      else if (cmd_en) en <= 1'b1;

      if (cmd_brk_off)               brk_req <= 1'b0;
      else if (cmd_brk_on && en)     brk_req <= 1'b1;

      if (take) begin
        hold_v <= 1'b0;
      end else if (in_valid && in_ready) begin
        hold_v <= 1'b1;
        hold_d <= in_data;
      end
    end
  end

  // R3
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !clr) |=> hold_v);

  // R7
  dis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_dis && !clr) |=> !in_ready);

  // R9
  brk_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_brk_on && !en && !brk_req) |=> !brk_req);
endmodule

// File: rtl/utx_serial.sv
module utx_serial
  import utx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              hold_v,
  input  logic [DATA_W-1:0] hold_d,
  input  logic              brk_req,
  output logic              txd,
  output logic              boundary,
  output logic              take,
  output logic              in_brk,
  output logic              idle
);
  localparam int FRAME = DATA_W + 2;
  localparam int CW    = $clog2(OVS);
  localparam int IW    = $clog2(FRAME);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [IW-1:0] IDX_STOP = IW'(FRAME - 1);

  utx_st_e           st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic              bit_end, go_brk;

  always_comb begin
    bit_end  = tick && (cnt == CNT_LAST);
    boundary = (st == ST_IDLE)
             | ((st == ST_CHAR) & bit_end & (idx == IDX_STOP))
             | ((st == ST_GAP) & bit_end);
    take     = boundary & hold_v;
    go_brk   = boundary & brk_req & ~hold_v;
    in_brk   = (st == ST_BRK);
    idle     = (st == ST_IDLE);
    case (st)
      ST_CHAR: txd = (idx == '0) ? 1'b0 : (idx == IDX_STOP) ? 1'b1 : sh[0];
      ST_BRK:  txd = 1'b0;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else if (clr) begin
      st  <= ST_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else if (take) begin
      st  <= ST_CHAR;
      cnt <= '0;
      idx <= '0;
      sh  <= hold_d;
    end else if (go_brk) begin
      st  <= ST_BRK;
      cnt <= '0;
    end else if (boundary) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_CHAR: if (tick) begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            idx <= idx + IW'(1);
            if (idx >= IW'(1) && idx <= IW'(DATA_W)) sh <= sh >> 1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_GAP: if (tick) cnt <= cnt + CW'(1);
        ST_BRK: if (!brk_req) begin
          st  <= ST_GAP;
          cnt <= '0;
        end
        default: ;
      endcase
    end
  end

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> !txd);

  // R11
  brk_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BRK && $past(st) != ST_BRK) |-> !$past(hold_v));

  // R12
  stop_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BRK && !brk_req && !clr) |=> (txd && st == ST_GAP));
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              cmd_rst,
  input  logic              cmd_brk_on,
  input  logic              cmd_brk_off,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              tx_empty,
  output logic              txd
);
  logic              en, hold_v, brk_req;
  logic [DATA_W-1:0] hold_d;
  logic              boundary, take, in_brk, idle;

  utx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rst),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .cmd_brk_on(cmd_brk_on), .cmd_brk_off(cmd_brk_off),
    .in_valid(in_valid), .in_data(in_data),
    .take(take), .boundary(boundary), .in_brk(in_brk),
    .in_ready(in_ready), .en(en), .hold_v(hold_v),
    .hold_d(hold_d), .brk_req(brk_req)
  );

  utx_serial #(.DATA_W(DATA_W), .OVS(OVS)) u_serial (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .tick(tick),
    .hold_v(hold_v), .hold_d(hold_d), .brk_req(brk_req),
    .txd(txd), .boundary(boundary), .take(take),
    .in_brk(in_brk), .idle(idle)
  );

  always_comb tx_empty = en & ~hold_v & idle;

  // R6
  empty_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && !in_brk));
endmodule

// File: tb/tb_uart_tx_brk.sv
`timescale 1ns/1ps
module tb_uart_tx_brk;
  localparam int TDIV   = 2;
  localparam int OVS    = 16;
  localparam int BITCYC = OVS * TDIV;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tick, cmd_en, cmd_dis, cmd_rst, cmd_brk_on, cmd_brk_off, in_valid;
  logic [7:0] in_data;
  logic in_ready, tx_empty, txd;

  uart_tx_brk #(.DATA_W(8), .OVS(OVS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .cmd_rst(cmd_rst), .cmd_brk_on(cmd_brk_on), .cmd_brk_off(cmd_brk_off),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_empty(tx_empty), .txd(txd)
  );

  int n_chk = 0, n_fail = 0, ncyc = 0, phase = 0;
  string req = "R1";

  // reference model: 0 idle, 1 frame, 2 break, 3 mark after break
  int m_mode = 0, m_t = 0;
  bit m_en = 0, m_hv = 0, m_brk = 0;
  logic [7:0] m_hd = 0;
  bit m_bits[$];

  task automatic chk(string r, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", r, what, act, exp);
    end
  endtask

  task automatic chk_le(string r, string what, int act, int lim);
    n_chk++;
    if (act > lim) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected<=%0d", r, what, act, lim);
    end
  endtask

  task automatic chk_ge(string r, string what, int act, int lim);
    n_chk++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected>=%0d", r, what, act, lim);
    end
  endtask

  task automatic chk8(string r, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic bit m_bound();
    return (m_mode == 0) ||
           (m_mode == 1 && tick && m_t == OVS-1 && m_bits.size() == 1) ||
           (m_mode == 3 && tick && m_t == OVS-1);
  endfunction

  function automatic bit m_txd();
    if (m_mode == 1) return m_bits[0];
    if (m_mode == 2) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_rdy();
    return m_en && !m_hv && m_mode != 2 && !(m_brk && m_bound());
  endfunction

  task automatic m_launch(bit old_brk, bit old_hv, ref bit took);
    took = 0;
    if (old_brk && !old_hv) begin
      m_mode = 2; m_t = 0;
    end else if (old_hv) begin
      m_mode = 1; m_t = 0; took = 1;
      m_bits.delete();
      m_bits.push_back(1'b0);
      for (int i = 0; i < 8; i++) m_bits.push_back(m_hd[i]);
      m_bits.push_back(1'b1);
    end else begin
      m_mode = 0; m_t = 0;
    end
  endtask

  task automatic m_update(bit acc);
    bit old_brk, old_hv, took;
    if (!rst_n || cmd_rst) begin
      m_mode = 0; m_t = 0; m_en = 0; m_hv = 0; m_brk = 0; m_hd = 0;
      m_bits.delete();
      return;
    end
    old_brk = m_brk; old_hv = m_hv; took = 0;
    if (cmd_brk_off) m_brk = 0;
    else if (cmd_brk_on && m_en) m_brk = 1;
    if (cmd_dis) m_en = 0;
    else if (cmd_en) m_en = 1;
    case (m_mode)
      0: m_launch(old_brk, old_hv, took);
      1: if (tick) begin
           if (m_t == OVS-1) begin
             m_t = 0;
             void'(m_bits.pop_front());
             if (m_bits.size() == 0) m_launch(old_brk, old_hv, took);
           end else m_t++;
         end
      2: if (!old_brk) begin m_mode = 3; m_t = 0; end
      default: if (tick) begin
           if (m_t == OVS-1) m_launch(old_brk, old_hv, took);
           else m_t++;
         end
    endcase
    if (took) m_hv = 0;
    else if (acc) begin m_hv = 1; m_hd = in_data; end
  endtask

  task automatic cyc();
    bit acc;
    tick = (phase == 0);
    #1;
    acc = 0;
    if (ncyc > 0) begin
      chk(req, "txd", txd, m_txd());
      chk(req, "in_ready", in_ready, m_rdy());
      chk(req, "tx_empty", tx_empty, m_en && !m_hv && m_mode == 0);
      acc = in_valid && m_rdy();
    end
    @(posedge clk);
    m_update(acc);
    @(negedge clk);
    phase = (phase + 1) % TDIV;
    ncyc++;
    cmd_en = 0; cmd_dis = 0; cmd_rst = 0; cmd_brk_on = 0; cmd_brk_off = 0;
    if (acc) in_valid = 0;
    if (ncyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog %s actual=hung expected=done", req);
      finish_run();
    end
  endtask

  task automatic idle_n(int n);
    repeat (n) cyc();
  endtask

  task automatic send(logic [7:0] b);
    in_valid = 1; in_data = b;
    while (in_valid) cyc();
  endtask

  task automatic capture(output logic [7:0] v);
    int k = 0;
    v = 'x;
    while (txd !== 1'b0 && k < 3000) begin cyc(); k++; end
    chk_le(req, "frame start wait", k, 2999);
    idle_n(BITCYC/2);
    chk(req, "start bit", txd, 1'b0);
    for (int i = 0; i < 8; i++) begin
      idle_n(BITCYC);
      v[i] = txd;
    end
    idle_n(BITCYC);
    chk(req, "stop bit", txd, 1'b1);
  endtask

  task automatic wait_level(logic lvl, output int k);
    k = 0;
    while (txd !== lvl && k < 4000) begin cyc(); k++; end
  endtask

  initial begin
    logic [7:0] v;
    int k, g;
    rst_n = 0; tick = 0; cmd_en = 0; cmd_dis = 0; cmd_rst = 0;
    cmd_brk_on = 0; cmd_brk_off = 0; in_valid = 0; in_data = 0;
    idle_n(3);
    rst_n = 1;
    cyc();

    req = "R1";
    chk("R1", "reset txd", txd, 1'b1);
    chk("R1", "reset in_ready", in_ready, 1'b0);
    chk("R1", "reset tx_empty", tx_empty, 1'b0);

    req = "R2";
    cmd_en = 1; cyc();
    chk("R2", "ready after enable", in_ready, 1'b1);
    chk("R2", "empty after enable", tx_empty, 1'b1);

    req = "R4";
    send(8'hA5); capture(v);
    chk8("R4", "frame data", v, 8'hA5);

    req = "R3";
    send(8'h3C); send(8'hF0);
    chk("R3", "ready low while held", in_ready, 1'b0);
    req = "R5";
    capture(v); chk8("R5", "first of pair", v, 8'h3C);
    wait_level(1'b0, k);
    chk_le("R5", "gap to next start", k, BITCYC/2 + 2);
    capture(v); chk8("R5", "second of pair", v, 8'hF0);

    req = "R6";
    idle_n(40);
    chk("R6", "empty when drained", tx_empty, 1'b1);

    req = "R7";
    send(8'h81); send(8'h7E);
    cmd_dis = 1; cyc();
    chk("R7", "ready after disable", in_ready, 1'b0);
    chk("R7", "empty after disable", tx_empty, 1'b0);
    capture(v); chk8("R7", "drained shifter", v, 8'h81);
    capture(v); chk8("R7", "drained holding", v, 8'h7E);
    idle_n(60);
    chk("R7", "idle line", txd, 1'b1);
    chk("R7", "empty stays low", tx_empty, 1'b0);

    req = "R8";
    cmd_en = 1; cmd_dis = 1; cyc();
    chk("R8", "both gives disabled", in_ready, 1'b0);

    req = "R9";
    cmd_brk_on = 1; cyc();
    idle_n(100);
    chk("R9", "break ignored disabled", txd, 1'b1);
    cmd_en = 1; cyc();
    idle_n(100);
    chk("R9", "no late break", txd, 1'b1);
    chk("R9", "empty after enable", tx_empty, 1'b1);

    req = "R10";
    cmd_brk_on = 1; cyc();
    wait_level(1'b0, k);
    chk_le("R10", "break start delay", k, 2*BITCYC);
    chk("R10", "ready low in break", in_ready, 1'b0);
    idle_n(200);
    chk("R10", "break held", txd, 1'b0);

    req = "R12";
    cmd_brk_off = 1; cyc();
    wait_level(1'b1, k);
    chk_le("R12", "break end delay", k, 2*BITCYC);
    g = 0;
    in_valid = 1; in_data = 8'h55;
    while (txd !== 1'b0 && g < 4000) begin cyc(); g++; end
    chk_ge("R12", "mark before start", g, BITCYC - TDIV);
    capture(v); chk8("R12", "char after break", v, 8'h55);

    req = "R11";
    idle_n(40);
    send(8'h0F); send(8'hC3);
    cmd_brk_on = 1; cyc();
    capture(v); chk8("R11", "first before break", v, 8'h0F);
    capture(v); chk8("R11", "second before break", v, 8'hC3);
    wait_level(1'b0, k);
    chk_le("R11", "break after drain", k, BITCYC);
    cmd_brk_off = 1; cyc();
    idle_n(100);
    chk("R11", "line high after", txd, 1'b1);

    req = "R13";
    send(8'h99); idle_n(60);
    cmd_rst = 1; cyc();
    chk("R13", "txd after reset cmd", txd, 1'b1);
    chk("R13", "ready after reset cmd", in_ready, 1'b0);
    chk("R13", "empty after reset cmd", tx_empty, 1'b0);
    idle_n(400);
    chk("R13", "held char dropped", txd, 1'b1);

    finish_run();
  end
endmodule